// File: doc/BRIEF.md
# Chip Event Interrupt Controller

This block collects two chip-level events into sticky status bits and turns each one into an active-low interrupt. The two interrupts leave on opposite sides of a bridge. The first event is a return to full power (D0) from one of the light low-power states, D1 or D2. It pulls the subsystem-side interrupt low. The second event is the release, a rising edge, of an active-low wake input. It pulls the host-side interrupt low.

Each event has a mask bit. Both mask bits come out of reset set, so no interrupt can fire until software clears a mask. Software sees a 16-bit register port with byte offsets:

- The status register at 0x82 clears a bit when a 1 is written to it.
- Writing a 1 at 0x84 sets a mask bit.
- Writing a 1 at 0x86 clears a mask bit.
- Reading either mask offset returns the current mask.

Two small state machines track the events:

- **Power tracker.** It has three states: `PT_FULL` (last sample D0), `PT_LIGHT` (last sample D1 or D2) and `PT_DEEP` (last sample D3). Each clock it moves to the state that matches the sampled power state. The D0 entry event is the `PT_LIGHT` to `PT_FULL` transition. Transitions that leave `PT_DEEP` or stay in `PT_FULL` raise nothing.
- **Wake tracker.** It has two states: `WK_IDLE` (synchronised pin high) and `WK_ASSERTED` (synchronised pin low). The wake event is the `WK_ASSERTED` to `WK_IDLE` transition.

Top module: `chip_evt_irq`

## Requirements
- R1: After reset the status bits are 0, both mask bits are 1, and both interrupt outputs are high.
- R2: The read port is combinational from `reg_addr`. It returns the following:
  - at 0x82: status bit 0 (power event) and bit 1 (wake event);
  - at 0x84 and at 0x86: mask bit 0 and mask bit 1;
  - bits 15:2 of every register: 0;
  - any other offset: 0.

  Bits 15:2 of written data are ignored.
- R3: The power state is encoded D0=0, D1=1, D2=2, D3=3. If the value sampled at one clock edge is D1 or D2 and the value at the next edge is D0, status bit 0 reads 1 after that second edge.
- R4: Entering D0 from D3, or holding D0, leaves status bit 0 unchanged.
- R5: A rising edge on `wake_n` sets status bit 1 on the third clock edge after the new level is set up, because of a two-flop synchroniser. A falling edge or a steady level sets nothing.
- R6: Writing a 1 to a status bit at 0x82 clears it. Writing a 0 leaves it unchanged.
- R7: Writing a 1 to a bit at 0x84 sets that mask bit. Writing a 0 leaves it unchanged.
- R8: Writing a 1 to a bit at 0x86 clears that mask bit. Writing a 0 leaves it unchanged.
- R9: `irq_sub_n` is low exactly while status bit 0 is 1 and mask bit 0 is 0.
- R10: `irq_host_n` is low exactly while status bit 1 is 1 and mask bit 1 is 0.
- R11: If an event and a write-one-to-clear of the same status bit take effect at the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_state | input | 2 | Current power state (D0=0 to D3=3) |
| wake_n | input | 1 | Active-low wake pin, asynchronous |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rd_data | output | 16 | Read data for `reg_addr` |
| irq_sub_n | output | 1 | Subsystem-side interrupt, active low |
| irq_host_n | output | 1 | Host-side interrupt, active low |

## Verification
The power input is driven through three paths: D0 to D1 to D0, D0 to D3 to D0, and D0 to D2 to D0. Together they separate a light-state return from a deep-state return and from a steady D0. The wake pin is held low and then released, with a read on each of the three cycles after the release. This separates edge detection from level detection and fixes the synchroniser latency. Masking is exercised in both directions, with writes of zeros and of upper bits. A power event that lands on the same edge as a clear of its status bit shows the priority of set over clear. A behavioural model in the bench follows every clock and is compared with both interrupt pins.

// File: rtl/chip_evt_pkg.sv
package chip_evt_pkg;
    localparam int EVT_PWR  = 0;
    localparam int EVT_WAKE = 1;
    localparam int NUM_EVT  = 2;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        PT_FULL  = 2'd0,
        PT_LIGHT = 2'd1,
        PT_DEEP  = 2'd2
    } pwr_trk_e;

    typedef enum logic {
        WK_ASSERTED = 1'b0,
        WK_IDLE     = 1'b1
    } wake_st_e;
endpackage

// File: rtl/cei_pwr_tracker.sv
module cei_pwr_tracker
    import chip_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_state,
    output logic       d0_entry
);
    pwr_trk_e   state_q;
    pwr_trk_e   state_d;
    pwr_state_e ps;

    assign ps = pwr_state_e'(pwr_state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PT_FULL;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (ps)
            PS_D0:        state_d = PT_FULL;
            PS_D1, PS_D2: state_d = PT_LIGHT;
            PS_D3:        state_d = PT_DEEP;
            default:      state_d = PT_FULL;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PT_LIGHT: d0_entry = (ps == PS_D0);
            PT_FULL:  d0_entry = 1'b0;
            PT_DEEP:  d0_entry = 1'b0;
            default:  d0_entry = 1'b0;
        endcase
    end
endmodule

// File: rtl/cei_wake_detect.sv
module cei_wake_detect
    import chip_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_n,
    output logic wake_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    wake_st_e               state_q;
    wake_st_e               state_d;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else if (i == 0) sync_q[i] <= wake_n;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = level ? WK_IDLE : WK_ASSERTED;
    end

    always_comb begin
        unique case (state_q)
            WK_ASSERTED: wake_rise = level;
            WK_IDLE:     wake_rise = 1'b0;
            default:     wake_rise = 1'b0;
        endcase
    end
endmodule

// File: rtl/cei_regs.sv
module cei_regs
    import chip_evt_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 16,
    parameter logic [7:0]  OFS_STATUS = 8'h82,
    parameter logic [7:0]  OFS_MSET   = 8'h84,
    parameter logic [7:0]  OFS_MCLR   = 8'h86
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] status,
    output logic [NUM_EVT-1:0] mask,
    output logic [DATA_W-1:0]  reg_rd_data
);
    localparam int PAD_W = DATA_W - NUM_EVT;

    logic               hit_status;
    logic               hit_mset;
    logic               hit_mclr;
    logic [NUM_EVT-1:0] wbits;

    assign hit_status = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    assign hit_mset   = reg_wr && (reg_addr == ADDR_W'(OFS_MSET));
    assign hit_mclr   = reg_wr && (reg_addr == ADDR_W'(OFS_MCLR));
    assign wbits      = reg_wdata[NUM_EVT-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~(hit_status ? wbits : '0)) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (hit_mset) begin
            mask <= mask | wbits;
        end else if (hit_mclr) begin
            mask <= mask & ~wbits;
        end
    end

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_STATUS))
            reg_rd_data = {{PAD_W{1'b0}}, status};
        else if (reg_addr == ADDR_W'(OFS_MSET) || reg_addr == ADDR_W'(OFS_MCLR))
            reg_rd_data = {{PAD_W{1'b0}}, mask};
        else
            reg_rd_data = '0;
    end
endmodule

// File: rtl/chip_evt_irq.sv
module chip_evt_irq
    import chip_evt_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pwr_state,
    input  logic              wake_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              irq_sub_n,
    output logic              irq_host_n
);
    logic [NUM_EVT-1:0] evt;
    logic [NUM_EVT-1:0] status_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] pending;

    cei_pwr_tracker u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_state (pwr_state),
        .d0_entry  (evt[EVT_PWR])
    );

    cei_wake_detect #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_n    (wake_n),
        .wake_rise (evt[EVT_WAKE])
    );

    cei_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .evt         (evt),
        .status      (status_q),
        .mask        (mask_q),
        .reg_rd_data (reg_rd_data)
    );

    assign pending    = status_q & ~mask_q;
    assign irq_sub_n  = ~pending[EVT_PWR];
    assign irq_host_n = ~pending[EVT_WAKE];
endmodule

// File: rtl/chip_evt_irq_chk.sv
module chip_evt_irq_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pwr_state,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [1:0]        status,
    input logic [1:0]        mask
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r3_light_to_d0: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(pwr_state) == 2'd1 || $past(pwr_state) == 2'd2)
         && pwr_state == 2'd0) |=> status[0]);

    a_r4_deep_to_d0: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(pwr_state) == 2'd3 && pwr_state == 2'd0 && !status[0])
        |=> !status[0]);

    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h82) && !reg_wdata[1] && status[1])
        |=> status[1]);

    a_r7_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h84) && reg_wdata[0]) |=> mask[0]);

    a_r8_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(8'h86) && reg_wdata[1]) |=> !mask[1]);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && reg_wr && reg_addr == ADDR_W'(8'h82) && reg_wdata[0]
         && ($past(pwr_state) == 2'd1 || $past(pwr_state) == 2'd2)
         && pwr_state == 2'd0) |=> status[0]);
endmodule

bind chip_evt_irq chip_evt_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_state (pwr_state),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .status    (status_q),
    .mask      (mask_q)
);

// File: tb/chip_evt_irq_tb_top.sv
`timescale 1ns/1ps
module chip_evt_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pwr_state = 2'd0;
    logic        wake_n = 1'b1;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rd_data;
    logic        irq_sub_n;
    logic        irq_host_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [1:0] m_status;
    logic [1:0] m_mask;
    logic       m_s1, m_s2, m_lvl, m_light;
    logic       e0, e1;

    always #2 clk = ~clk;

    chip_evt_irq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_state   (pwr_state),
        .wake_n      (wake_n),
        .reg_addr    (reg_addr),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rd_data (reg_rd_data),
        .irq_sub_n   (irq_sub_n),
        .irq_host_n  (irq_host_n)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_status = 2'b00; m_mask = 2'b11;
            m_s1 = 1'b1; m_s2 = 1'b1; m_lvl = 1'b1; m_light = 1'b0;
        end else begin
            e0 = m_light && (pwr_state == 2'd0);
            e1 = !m_lvl && m_s2;
            if (reg_wr && reg_addr == 8'h82) m_status = m_status & ~reg_wdata[1:0];
            if (reg_wr && reg_addr == 8'h84) m_mask = m_mask | reg_wdata[1:0];
            if (reg_wr && reg_addr == 8'h86) m_mask = m_mask & ~reg_wdata[1:0];
            m_status = m_status | {e1, e0};
            m_lvl = m_s2; m_s2 = m_s1; m_s1 = wake_n;
            m_light = (pwr_state == 2'd1) || (pwr_state == 2'd2);
        end
    end

    // per-clock comparison against the model (R9, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9", {15'b0, irq_sub_n},  {15'b0, !(m_status[0] && !m_mask[0])});
            chk("R10", {15'b0, irq_host_n}, {15'b0, !(m_status[1] && !m_mask[1])});
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [7:0] a, logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rd_data, exp);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", {14'b0, irq_host_n, irq_sub_n}, 16'h0003);
        rd("R1", 8'h82, 16'h0000);
        rd("R1", 8'h84, 16'h0003);
        rd("R8", 8'h86, 16'h0003);
        rd("R2", 8'h80, 16'h0000);
        // unmask both
        wr(8'h86, 16'h0003);
        rd("R8", 8'h84, 16'h0000);
        // D1 -> D0
        @(negedge clk); pwr_state = 2'd1;
        wait_cyc(2);
        pwr_state = 2'd0;
        wait_cyc(2);
        rd("R3", 8'h82, 16'h0001);
        chk("R9", {15'b0, irq_sub_n}, 16'h0000);
        // W1C
        wr(8'h82, 16'h0002);
        rd("R6", 8'h82, 16'h0001);
        wr(8'h82, 16'h0001);
        rd("R6", 8'h82, 16'h0000);
        chk("R9", {15'b0, irq_sub_n}, 16'h0001);
        // D3 -> D0 does nothing
        pwr_state = 2'd3;
        wait_cyc(2);
        pwr_state = 2'd0;
        wait_cyc(3);
        rd("R4", 8'h82, 16'h0000);
        // D2 -> D0
        pwr_state = 2'd2;
        wait_cyc(2);
        pwr_state = 2'd0;
        wait_cyc(2);
        rd("R3", 8'h82, 16'h0001);
        wr(8'h82, 16'h0001);
        // wake: falling edge no effect, rising edge after three edges
        @(negedge clk); wake_n = 1'b0;
        wait_cyc(6);
        rd("R5", 8'h82, 16'h0000);
        @(negedge clk); wake_n = 1'b1;
        rd("R5", 8'h82, 16'h0000);
        rd("R5", 8'h82, 16'h0000);
        rd("R5", 8'h82, 16'h0002);
        chk("R10", {15'b0, irq_host_n}, 16'h0000);
        // set mask bit 1
        wr(8'h84, 16'h0002);
        rd("R7", 8'h84, 16'h0002);
        chk("R10", {15'b0, irq_host_n}, 16'h0001);
        rd("R7", 8'h82, 16'h0002);
        wr(8'h84, 16'hFFFC);
        rd("R2", 8'h84, 16'h0002);
        wr(8'h86, 16'h0000);
        rd("R8", 8'h84, 16'h0002);
        // set wins over clear
        @(negedge clk); pwr_state = 2'd1;
        wait_cyc(2);
        pwr_state = 2'd0;
        reg_addr = 8'h82; reg_wdata = 16'h0001; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd("R11", 8'h82, 16'h0003);
        wr(8'h82, 16'h0003);
        rd("R6", 8'h82, 16'h0000);
        wait_cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule